// File: doc/BRIEF.md
# Tick Compare Timer

This block is a free-running tick counter with a single compare channel behind a 32-bit register bus. A prescaler divides the input clock by three, and the counter advances on each prescaler tick. A build-time parameter removes the divider so that the counter advances on every clock. Software reads the count as two 32-bit words. Both words are live and unlatched, so a reader of the 64-bit value reads the upper word again and retries until it matches.

To arm an event, software writes a compare value as a low word and an upper word, then sets the enable bit. On the first tick where the count is at or above the compare value, a sticky status flag sets. That flag drives the interrupt unless the mask bit is set. The only acknowledge is to clear the enable bit, which also clears the flag. A second build parameter moves the two count words up by 0x20000 for an alternate address layout.

Top module: `tick_compare_timer`

## Requirements
- R1: While reset is asserted, every mapped register reads zero and `irqOut` is 0. After reset the count starts from zero.
- R2: With the divider in place (default), the count increases by exactly one every three clocks, and it holds between ticks.
- R3: With the divider removed, the count increases by one on every clock.
- R4: The count low word reads at byte offset 0x8 and the high word at 0xC, or at 0x20008 and 0x2000C in the alternate layout. Each read returns the current, unlatched value.
- R5: The compare low word is at 0x10020 and is stored as 32 bits. The compare upper word is at 0x10024 and keeps only bits [19:0], which read back with the upper bits zero. Bits [31:20] written there take no part in the comparison.
- R6: The control register is at 0x1002C. Bit 0 is enable and bit 1 is the interrupt mask, and both are writable. Bit 2 is the read-only status flag. Bits [31:3] read zero.
- R7: The status flag sets on the first tick where enable is 1 and the 64-bit count is greater than or equal to the zero-extended 52-bit compare value. It then stays set.
- R8: Writing the control register with bit 0 equal to 0 clears the status flag and drives `irqOut` low from the next clock. The flag never sets while enable is 0.
- R9: `irqOut` is high exactly when status is 1 and mask is 0. Setting the mask leaves the status flag unchanged.
- R10: A read of an unmapped offset returns zero, and a write to an unmapped offset changes no register. `busRdata` is zero while `busRdEn` is low.
- R11: Enabling with a compare value already at or below the count sets the status flag on the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe, taken at the rising edge |
| busRdEn | input | 1 | Read enable, combinational data return |
| busAddr | input | 18 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, zero unless a mapped register is read |
| irqOut | output | 1 | Active-high interrupt request |

## Verification
Read data is combinational, so it is due in the same cycle as `busRdEn`. Register writes take effect at the clock edge that samples `busWrEn`. The status flag and `irqOut` change at the first tick edge that follows the qualifying condition. The bench drives the bus on falling edges and samples 1 ns later, which puts every observation between rising edges with a known number of edges elapsed. In the no-divider instance each clock is a tick, so `irqOut` is compared cycle by cycle against the count that is read in the same cycle, across the whole compare window.

// File: rtl/tct_pkg.sv
package tct_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 18;

  // Byte offsets of the register window
  localparam logic [ADDR_W-1:0] OFS_CNT_LO    = 18'h00008;
  localparam logic [ADDR_W-1:0] OFS_CNT_HI    = 18'h0000C;
  localparam logic [ADDR_W-1:0] OFS_ALT_FRAME = 18'h20000;
  localparam logic [ADDR_W-1:0] OFS_CMP_LO    = 18'h10020;
  localparam logic [ADDR_W-1:0] OFS_CMP_HI    = 18'h10024;
  localparam logic [ADDR_W-1:0] OFS_CTRL      = 18'h1002C;

  // Control register bit positions
  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_MASK_BIT = 1;

  typedef struct packed {
    logic             wrCmpLo;
    logic             wrCmpHi;
    logic             wrCtrl;
    logic [BUS_W-1:0] data;
  } tctStrobe_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CTRL
  } tctSel_t;
endpackage

// File: rtl/tct_datapath.sv
module tct_datapath
  import tct_pkg::*;
#(
  parameter bit          USE_DIV     = 1'b1,
  parameter int unsigned DIV_RATIO   = 3,
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned CMP_HI_BITS = 20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tctStrobe_t             strobe,
  output logic                   tick,
  output logic [CNT_W-1:0]       count,
  output logic [BUS_W-1:0]       cmpLo,
  output logic [CMP_HI_BITS-1:0] cmpHi,
  output logic                   en,
  output logic                   mask,
  output logic                   status,
  output logic                   irq
);
  localparam int unsigned CMP_W = BUS_W + CMP_HI_BITS;
  localparam int unsigned DIV_W = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;

  logic [CMP_W-1:0] cmpVal;
  logic             hit;

  // Prescaler: one tick per DIV_RATIO clocks, or every clock
  generate
    if (USE_DIV) begin : g_div
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DIV_RATIO - 1);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 divCnt <= '0;
        else if (divCnt == DIV_LAST) divCnt <= '0;
        else                       divCnt <= divCnt + 1'b1;
      end
      assign tick = (divCnt == DIV_LAST);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     count <= '0;
    else if (tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLo <= '0;
      cmpHi <= '0;
    end else begin
      if (strobe.wrCmpLo) cmpLo <= strobe.data;
      if (strobe.wrCmpHi) cmpHi <= strobe.data[CMP_HI_BITS-1:0];
    end
  end

  assign cmpVal = {cmpHi, cmpLo};
  assign hit    = (count >= CNT_W'(cmpVal));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      en   <= 1'b0;
      mask <= 1'b0;
    end else if (strobe.wrCtrl) begin
      en   <= strobe.data[CTRL_EN_BIT];
      mask <= strobe.data[CTRL_MASK_BIT];
    end
  end

  // Clearing enable is the acknowledge; it wins over a same-cycle match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                         status <= 1'b0;
    else if (strobe.wrCtrl && !strobe.data[CTRL_EN_BIT]) status <= 1'b0;
    else if (tick && en && hit)                        status <= 1'b1;
  end

  assign irq = status & ~mask;
endmodule

// File: rtl/tct_ctrl.sv
module tct_ctrl
  import tct_pkg::*;
#(
  parameter bit          ALT_LAYOUT  = 1'b0,
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned CMP_HI_BITS = 20
) (
  input  logic                   wrEn,
  input  logic                   rdEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BUS_W-1:0]       wdata,
  input  logic [CNT_W-1:0]       count,
  input  logic [BUS_W-1:0]       cmpLo,
  input  logic [CMP_HI_BITS-1:0] cmpHi,
  input  logic                   en,
  input  logic                   mask,
  input  logic                   status,
  output tctStrobe_t             strobe,
  output logic [BUS_W-1:0]       rdata
);
  localparam logic [ADDR_W-1:0] FRAME    = ALT_LAYOUT ? OFS_ALT_FRAME : '0;
  localparam logic [ADDR_W-1:0] CNT_LO_A = OFS_CNT_LO + FRAME;
  localparam logic [ADDR_W-1:0] CNT_HI_A = OFS_CNT_HI + FRAME;

  tctSel_t sel;

  always_comb begin
    if (addr == CNT_LO_A)        sel = SEL_CNT_LO;
    else if (addr == CNT_HI_A)   sel = SEL_CNT_HI;
    else if (addr == OFS_CMP_LO) sel = SEL_CMP_LO;
    else if (addr == OFS_CMP_HI) sel = SEL_CMP_HI;
    else if (addr == OFS_CTRL)   sel = SEL_CTRL;
    else                         sel = SEL_NONE;
  end

  // Only the compare words and the control register accept writes
  always_comb begin
    strobe.wrCmpLo = wrEn && (sel == SEL_CMP_LO);
    strobe.wrCmpHi = wrEn && (sel == SEL_CMP_HI);
    strobe.wrCtrl  = wrEn && (sel == SEL_CTRL);
    strobe.data    = wdata;
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      case (sel)
        SEL_CNT_LO: rdata = count[BUS_W-1:0];
        SEL_CNT_HI: rdata = BUS_W'(count[CNT_W-1:BUS_W]);
        SEL_CMP_LO: rdata = cmpLo;
        SEL_CMP_HI: rdata = BUS_W'(cmpHi);
        SEL_CTRL:   rdata = BUS_W'({status, mask, en});
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_compare_timer.sv
module tick_compare_timer
  import tct_pkg::*;
#(
  parameter bit          USE_DIV     = 1'b1,
  parameter bit          ALT_LAYOUT  = 1'b0,
  parameter int unsigned DIV_RATIO   = 3,
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned CMP_HI_BITS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic              irqOut
);
  tctStrobe_t             strobe;
  logic                   tick;
  logic [CNT_W-1:0]       count;
  logic [BUS_W-1:0]       cmpLo;
  logic [CMP_HI_BITS-1:0] cmpHi;
  logic                   en;
  logic                   mask;
  logic                   status;

  tct_ctrl #(
    .ALT_LAYOUT (ALT_LAYOUT),
    .CNT_W      (CNT_W),
    .CMP_HI_BITS(CMP_HI_BITS)
  ) uCtrl (
    .wrEn  (busWrEn),
    .rdEn  (busRdEn),
    .addr  (busAddr),
    .wdata (busWdata),
    .count (count),
    .cmpLo (cmpLo),
    .cmpHi (cmpHi),
    .en    (en),
    .mask  (mask),
    .status(status),
    .strobe(strobe),
    .rdata (busRdata)
  );

  tct_datapath #(
    .USE_DIV    (USE_DIV),
    .DIV_RATIO  (DIV_RATIO),
    .CNT_W      (CNT_W),
    .CMP_HI_BITS(CMP_HI_BITS)
  ) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .tick  (tick),
    .count (count),
    .cmpLo (cmpLo),
    .cmpHi (cmpHi),
    .en    (en),
    .mask  (mask),
    .status(status),
    .irq   (irqOut)
  );
endmodule

// File: rtl/tct_checker.sv
module tct_checker
  import tct_pkg::*;
#(
  parameter bit          USE_DIV     = 1'b1,
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned CMP_HI_BITS = 20
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   busWrEn,
  input logic [ADDR_W-1:0]      busAddr,
  input logic                   wrEnBit,
  input logic                   irqOut,
  input logic                   tick,
  input logic [CNT_W-1:0]       count,
  input logic [BUS_W-1:0]       cmpLo,
  input logic [CMP_HI_BITS-1:0] cmpHi,
  input logic                   en,
  input logic                   mask,
  input logic                   status
);
  logic reached;
  assign reached = count >= CNT_W'({cmpHi, cmpLo});

  // R2: each tick advances the count by one
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> count == $past(count) + 1'b1);

  // R2: no tick, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(count));

  generate
    if (USE_DIV) begin : g_gap
      // R2: divided ticks never come back to back
      p_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate

  // R7: a rising status follows an enabled tick at or past the compare value
  p_fire_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status) |-> $past(en && tick && reached));

  // R8: writing enable low acknowledges
  p_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_CTRL && !wrEnBit) |=> (!irqOut && !status));

  // R8: status is never held while disabled
  p_status_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    status |-> en);

  // R9: a set mask keeps the line low
  p_mask_r9: assert property (@(posedge clk) disable iff (!rstN)
    mask |-> !irqOut);
endmodule

bind tick_compare_timer tct_checker #(
  .USE_DIV    (USE_DIV),
  .CNT_W      (CNT_W),
  .CMP_HI_BITS(CMP_HI_BITS)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .busWrEn(busWrEn),
  .busAddr(busAddr),
  .wrEnBit(busWdata[0]),
  .irqOut (irqOut),
  .tick   (tick),
  .count  (count),
  .cmpLo  (cmpLo),
  .cmpHi  (cmpHi),
  .en     (en),
  .mask   (mask),
  .status (status)
);

// File: tb/sim_tick_compare_timer.sv
`timescale 1ns/1ps
module sim_tick_compare_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wr0 = 1'b0;
  logic        wr1 = 1'b0;
  logic        rdEn = 1'b0;
  logic [17:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd0;
  logic [31:0] rd1;
  logic        irq0;
  logic        irq1;
  int          checks = 0;
  int          failures = 0;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  // Default build: divider on, standard layout
  tick_compare_timer u0 (
    .clk(clk), .rstN(rstN), .busWrEn(wr0), .busRdEn(rdEn), .busAddr(addr),
    .busWdata(wdata), .busRdata(rd0), .irqOut(irq0)
  );

  // Divider removed, alternate count layout
  tick_compare_timer #(.USE_DIV(1'b0), .ALT_LAYOUT(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .busWrEn(wr1), .busRdEn(rdEn), .busAddr(addr),
    .busWdata(wdata), .busRdata(rd1), .irqOut(irq1)
  );

  localparam logic [17:0] A_CLO  = 18'h00008;
  localparam logic [17:0] A_CHI  = 18'h0000C;
  localparam logic [17:0] A_ACLO = 18'h20008;
  localparam logic [17:0] A_ACHI = 18'h2000C;
  localparam logic [17:0] A_KLO  = 18'h10020;
  localparam logic [17:0] A_KHI  = 18'h10024;
  localparam logic [17:0] A_CTL  = 18'h1002C;

  typedef struct packed {
    logic        isRd;
    logic [17:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  req;
  } vec_t;

  // Register access table on u0: R5 compare words, R10 unmapped, R6 control
  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, A_KLO,     32'hDEADBEEF, 32'h0,        4'd5},
    '{1'b1, A_KLO,     32'h0,        32'hDEADBEEF, 4'd5},
    '{1'b0, A_KHI,     32'hFFFFFFFF, 32'h0,        4'd5},
    '{1'b1, A_KHI,     32'h0,        32'h000FFFFF, 4'd5},
    '{1'b0, 18'h10000, 32'h12345678, 32'h0,        4'd10},
    '{1'b1, 18'h10000, 32'h0,        32'h0,        4'd10},
    '{1'b1, 18'h10028, 32'h0,        32'h0,        4'd10},
    '{1'b1, A_KLO,     32'h0,        32'hDEADBEEF, 4'd10},
    '{1'b1, A_ACLO,    32'h0,        32'h0,        4'd10},
    '{1'b0, A_CTL,     32'h00000002, 32'h0,        4'd6},
    '{1'b1, A_CTL,     32'h0,        32'h00000002, 4'd6},
    '{1'b0, A_CTL,     32'hFFFFFFFA, 32'h0,        4'd6},
    '{1'b1, A_CTL,     32'h0,        32'h00000002, 4'd6},
    '{1'b0, A_CTL,     32'h0,        32'h0,        4'd6},
    '{1'b1, A_CTL,     32'h0,        32'h0,        4'd6},
    '{1'b0, A_KHI,     32'h0,        32'h0,        4'd5}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int unit, input logic [17:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr0 = (unit == 0); wr1 = (unit == 1);
    @(posedge clk);
    #1 wr0 = 1'b0; wr1 = 1'b0;
  endtask

  task automatic busRead(input int unit, input logic [17:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 d = (unit == 0) ? rd0 : rd1;
    rdEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    logic [31:0] v2;
    logic [31:0] k;

    // R1: reset state
    repeat (2) @(posedge clk);
    busRead(0, A_CLO, v);  check("R1 count low in reset", v, 0);
    busRead(0, A_CTL, v);  check("R1 control in reset", v, 0);
    busRead(0, A_KLO, v);  check("R1 compare low in reset", v, 0);
    busRead(1, A_ACLO, v); check("R1 alt count in reset", v, 0);
    check("R1 irq in reset", {31'b0, irq0}, 0);
    @(negedge clk) rstN = 1'b1;

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRd) begin
        busRead(0, VECS[i].a, v);
        check($sformatf("R%0d table entry %0d", VECS[i].req, i), v, VECS[i].e);
      end else begin
        busWrite(0, VECS[i].a, VECS[i].d);
      end
    end
    busWrite(0, A_KLO, 32'h0);
    busRead(0, A_KHI, v); check("R5 compare high cleared", v, 0);

    // R10: no read data without read enable
    @(negedge clk); addr = A_KLO; #1 check("R10 idle bus data", rd0, 0);

    // R2: one tick per three clocks
    for (int n = 0; n < 3; n++) begin
      busRead(0, A_CLO, v);
      repeat (2) @(negedge clk);
      busRead(0, A_CLO, v2);
      check("R2 three-clock step", v2 - v, 1);
    end
    busRead(0, A_CHI, v); check("R4 count high word", v, 0);

    // R3 / R4: no divider, alternate layout
    for (int n = 0; n < 3; n++) begin
      busRead(1, A_ACLO, v);
      busRead(1, A_ACLO, v2);
      check("R3 per-clock step", v2 - v, 1);
    end
    busRead(1, A_ACHI, v); check("R4 alt count high word", v, 0);
    busRead(1, A_CLO, v);  check("R4 standard offset unmapped in alt layout", v, 0);

    // R7: exact firing point on u1 with a delta of 0x100
    busRead(1, A_ACLO, v);
    k = v + 32'h100;
    busWrite(1, A_KLO, k);
    busWrite(1, A_CTL, 32'h1);
    for (int n = 0; n < 32'h120; n++) begin
      busRead(1, A_ACLO, v);
      check("R7 irq tracks count past compare", {31'b0, irq1}, {31'b0, (v > k)});
    end
    busRead(1, A_CTL, v); check("R6 status bit visible", v, 32'h5);

    // R9: mask hides the line, status kept
    busWrite(1, A_CTL, 32'h3);
    busRead(1, A_CTL, v); check("R9 status kept under mask", v, 32'h7);
    check("R9 masked irq low", {31'b0, irq1}, 0);
    busWrite(1, A_CTL, 32'h1);
    @(negedge clk); #1 check("R9 unmasked irq high", {31'b0, irq1}, 1);

    // R8: clearing enable acknowledges
    busWrite(1, A_CTL, 32'h0);
    busRead(1, A_CTL, v); check("R8 status cleared", v, 0);
    repeat (5) @(negedge clk);
    #1 check("R8 no refire while disabled", {31'b0, irq1}, 0);

    // R11: compare already passed fires on the next tick
    busWrite(1, A_CTL, 32'h1);
    @(negedge clk); #1 check("R11 not yet set", {31'b0, irq1}, 0);
    @(negedge clk); #1 check("R11 set on next tick", {31'b0, irq1}, 1);

    // R7: upper compare half takes part (u0)
    busWrite(0, A_KLO, 32'h0);
    busWrite(0, A_KHI, 32'h1);
    busWrite(0, A_CTL, 32'h1);
    repeat (20) @(negedge clk);
    #1 check("R7 high compare half blocks", {31'b0, irq0}, 0);
    busRead(0, A_CTL, v); check("R7 status clear below compare", v, 32'h1);

    // R5: bits above [19:0] of the compare high word are ignored
    busWrite(0, A_CTL, 32'h0);
    busWrite(0, A_KHI, 32'hFFF00000);
    busWrite(0, A_KLO, 32'h10);
    busWrite(0, A_CTL, 32'h1);
    repeat (4) @(negedge clk);
    #1 check("R5 upper high bits ignored in compare", {31'b0, irq0}, 1);
    busWrite(0, A_CTL, 32'h0);
    @(negedge clk); #1 check("R8 ack on divided instance", {31'b0, irq0}, 0);

    finishRun();
  end
endmodule